// File: doc/BRIEF.md
# Fill-Level Triggered DMA Write Launcher

This block sits between a deserializer and a host memory-write path. Incoming data words are pushed into a receive FIFO. Software programs two registers: a destination host byte address and a transfer size in bytes. There is no start command. As soon as the FIFO holds at least the programmed number of bytes, the block starts a memory-write transfer on its own.

A transfer leaves the block as a series of bursts. Each burst is a header handshake that carries the address and the byte length. The header is followed by one data beat per word, and the final beat of the burst is marked. A burst never exceeds a parameterised maximum length, and it never crosses a 4 KB page boundary.

The address and size are copied when a transfer starts. Software may therefore rewrite the registers while a transfer is in progress, and the new values apply to the next transfer. At the end of each transfer the block raises a sticky done flag and advances a transfer counter. A word that arrives while the FIFO is full is dropped, and a sticky overflow flag records the loss.

Top module: `dma_wr_launcher`

## Requirements
- R1: After reset, `hdr_valid`, `wr_valid`, `xfer_done` and `ovf_err` are 0, `xfer_count` is 0, and both configuration registers read as 0.
- R2: A word on `in_data` with `in_valid` high is stored in the FIFO. A transfer starts when the FIFO fill, counted in bytes (4 per word), reaches or exceeds a nonzero size register. `hdr_valid` rises one clock after the edge at which the threshold is first met. A size of 0 never starts a transfer.
- R3: Data beats carry the stored words in arrival order. `wr_last` is high on the final beat of each burst.
- R4: The length of each burst is the smallest of three values: the bytes still to be sent, `MAX_BURST` (128), and the bytes left before the next 4096-byte boundary. The first burst uses the programmed address, and each later burst starts at the previous address plus the previous length.
- R5: While `hdr_valid` is high and `hdr_ready` is low, `hdr_valid`, `hdr_addr` and `hdr_len` hold their values.
- R6: The address and size are captured when a transfer starts. Register writes made during a transfer do not affect it, and they take effect on the following transfer.
- R7: When the last beat of a transfer is accepted, `xfer_done` becomes 1 and `xfer_count` increases by exactly 1. `sts_clr` clears `xfer_done` and leaves `xfer_count` unchanged.
- R8: A word presented while the FIFO is full is discarded and never sent. It sets `ovf_err`, which stays 1 until `sts_clr`.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_data` and `wr_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming word strobe |
| in_data | input | DATA_W | Incoming deserialized word |
| cfg_addr_we | input | 1 | Write strobe for the address register |
| cfg_addr_wdata | input | ADDR_W | New host byte address |
| cfg_size_we | input | 1 | Write strobe for the size register |
| cfg_size_wdata | input | SIZE_W | New transfer size in bytes |
| sts_clr | input | 1 | Clears the sticky done and overflow flags |
| cfg_addr | output | ADDR_W | Address register readback |
| cfg_size | output | SIZE_W | Size register readback |
| xfer_done | output | 1 | Sticky transfer-complete flag |
| xfer_count | output | CNT_W | Count of completed transfers |
| ovf_err | output | 1 | Sticky FIFO overflow flag |
| hdr_valid | output | 1 | Burst header valid |
| hdr_ready | input | 1 | Burst header accepted |
| hdr_addr | output | ADDR_W | Burst start address |
| hdr_len | output | LEN_W | Burst length in bytes |
| wr_valid | output | 1 | Data beat valid |
| wr_ready | input | 1 | Data beat accepted |
| wr_data | output | DATA_W | Data beat payload |
| wr_last | output | 1 | Final beat of the burst |

## Verification
Each result has a fixed cycle at which it becomes due, and the bench samples on falling edges so that it reads the state settled after the preceding rising edge.

- **Header start (R2):** The header must be absent at the falling edge right after the threshold-reaching push, and present at the next one.
- **Headers and beats (R3, R4, R5, R9):** Each header and beat is compared only on a falling edge where valid is high. The expected burst advances only when ready was also high for the coming edge, so stalled cycles re-check the held values.
- **Status (R7, R8):** The done flag and the counter are read at the falling edge after the last accepted beat. The overflow flag is read at the falling edge after the dropped push.

// File: rtl/dwl_pkg.sv
package dwl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HDR  = 2'd1,
      ST_DATA = 2'd2
   } dwl_state_e;

endpackage

// File: rtl/dwl_fifo.sv
module dwl_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic          full,
   output logic          empty,
   output logic [CW-1:0] count
);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("dwl_fifo: DEPTH must be a power of two >= 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [CW-1:0] wp, rp;

   assign count = wp - rp;
   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
   assign dout  = mem[rp[AW-1:0]];

   always_ff @(posedge clk) begin
      if (push) mem[wp[AW-1:0]] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push) wp <= wp + CW'(1);
         if (pop)  rp <= rp + CW'(1);
      end
   end

endmodule

// File: rtl/dwl_burst_len.sv
module dwl_burst_len #(
   parameter int ADDR_W     = 32,
   parameter int SIZE_W     = 16,
   parameter int MAX_BURST  = 128,
   parameter int PAGE_BYTES = 4096,
   localparam int LEN_W     = $clog2(MAX_BURST) + 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] remain,
   output logic [LEN_W-1:0]  len
);

   logic [31:0] offs, gap, cap, rem32;

   assign offs  = 32'(addr) & 32'(PAGE_BYTES - 1);
   assign gap   = 32'(PAGE_BYTES) - offs;
   assign rem32 = 32'(remain);

   if (MAX_BURST == PAGE_BYTES) begin : g_page_only
      assign cap = gap;
   end else begin : g_page_and_max
      assign cap = (gap < 32'(MAX_BURST)) ? gap : 32'(MAX_BURST);
   end

   assign len = LEN_W'((rem32 < cap) ? rem32 : cap);

endmodule

// File: rtl/dma_wr_launcher.sv
module dma_wr_launcher #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int SIZE_W     = 16,
   parameter int CNT_W      = 16,
   parameter int FIFO_DEPTH = 64,
   parameter int MAX_BURST  = 128,
   parameter int PAGE_BYTES = 4096,
   localparam int BYTES     = DATA_W / 8,
   localparam int BSH       = $clog2(BYTES),
   localparam int LEN_W     = $clog2(MAX_BURST) + 1,
   localparam int FCW       = $clog2(FIFO_DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              cfg_addr_we,
   input  logic [ADDR_W-1:0] cfg_addr_wdata,
   input  logic              cfg_size_we,
   input  logic [SIZE_W-1:0] cfg_size_wdata,
   input  logic              sts_clr,
   output logic [ADDR_W-1:0] cfg_addr,
   output logic [SIZE_W-1:0] cfg_size,
   output logic              xfer_done,
   output logic [CNT_W-1:0]  xfer_count,
   output logic              ovf_err,
   output logic              hdr_valid,
   input  logic              hdr_ready,
   output logic [ADDR_W-1:0] hdr_addr,
   output logic [LEN_W-1:0]  hdr_len,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [DATA_W-1:0] wr_data,
   output logic              wr_last
);
   import dwl_pkg::*;

   if (DATA_W % 8 != 0 || (1 << BSH) != BYTES) begin : g_bad_data_w
      $error("dma_wr_launcher: DATA_W must be a power-of-two number of bytes");
   end
   if (MAX_BURST > PAGE_BYTES || MAX_BURST % BYTES != 0) begin : g_bad_burst
      $error("dma_wr_launcher: MAX_BURST must be word-sized and fit a page");
   end
   if (SIZE_W > 31 || (1 << $clog2(PAGE_BYTES)) != PAGE_BYTES) begin : g_bad_misc
      $error("dma_wr_launcher: SIZE_W too wide or PAGE_BYTES not a power of two");
   end

   localparam logic [ADDR_W-1:0] AMASK = ~ADDR_W'(BYTES - 1);
   localparam logic [SIZE_W-1:0] SMASK = ~SIZE_W'(BYTES - 1);

   dwl_state_e        state;
   logic [ADDR_W-1:0] addr_reg, cur_addr;
   logic [SIZE_W-1:0] size_reg, size_eff, remain;
   logic [LEN_W-1:0]  beats, len_q, blen;
   logic              f_push, f_pop, f_full, f_empty;
   logic [FCW-1:0]    f_count;
   logic [DATA_W-1:0] f_dout;
   logic [31:0]       fill_bytes;
   logic              trigger, last_burst, xfer_fin;

   // software-visible configuration
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_reg <= '0;
         size_reg <= '0;
      end else begin
         if (cfg_addr_we) addr_reg <= cfg_addr_wdata;
         if (cfg_size_we) size_reg <= cfg_size_wdata;
      end
   end
   assign cfg_addr = addr_reg;
   assign cfg_size = size_reg;
   assign size_eff = size_reg & SMASK;

   // receive buffer
   assign f_push = in_valid && !f_full;
   assign f_pop  = wr_valid && wr_ready;

   dwl_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (f_push),
      .din   (in_data),
      .pop   (f_pop),
      .dout  (f_dout),
      .full  (f_full),
      .empty (f_empty),
      .count (f_count)
   );

   // burst segmentation
   dwl_burst_len #(
      .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
      .MAX_BURST(MAX_BURST), .PAGE_BYTES(PAGE_BYTES)
   ) u_blen (
      .addr   (cur_addr),
      .remain (remain),
      .len    (blen)
   );

   assign fill_bytes = 32'(f_count) << BSH;
   assign trigger    = (state == ST_IDLE) && (size_eff != '0) &&
                       (fill_bytes >= 32'(size_eff));
   assign last_burst = (32'(remain) == 32'(len_q));
   assign xfer_fin   = (state == ST_DATA) && f_pop &&
                       (beats == LEN_W'(1)) && last_burst;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cur_addr <= '0;
         remain   <= '0;
         beats    <= '0;
         len_q    <= '0;
      end else begin
         case (state)
            ST_IDLE: if (trigger) begin
               cur_addr <= addr_reg & AMASK;
               remain   <= size_eff;
               state    <= ST_HDR;
            end
            ST_HDR: if (hdr_ready) begin
               len_q <= blen;
               beats <= blen >> BSH;
               state <= ST_DATA;
            end
            ST_DATA: if (f_pop) begin
               beats <= beats - LEN_W'(1);
               if (beats == LEN_W'(1)) begin
                  cur_addr <= cur_addr + ADDR_W'(len_q);
                  remain   <= remain - SIZE_W'(len_q);
                  state    <= last_burst ? ST_IDLE : ST_HDR;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // completion and error status
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xfer_done  <= 1'b0;
         xfer_count <= '0;
         ovf_err    <= 1'b0;
      end else begin
         if (xfer_fin)              xfer_done <= 1'b1;
         else if (sts_clr)          xfer_done <= 1'b0;
         if (xfer_fin)              xfer_count <= xfer_count + CNT_W'(1);
         if (in_valid && f_full)    ovf_err <= 1'b1;
         else if (sts_clr)          ovf_err <= 1'b0;
      end
   end

   assign hdr_valid = (state == ST_HDR);
   assign hdr_addr  = cur_addr;
   assign hdr_len   = blen;
   assign wr_valid  = (state == ST_DATA) && !f_empty;
   assign wr_data   = f_dout;
   assign wr_last   = (state == ST_DATA) && (beats == LEN_W'(1));

endmodule

// File: rtl/dwl_launcher_chk.sv
module dwl_launcher_chk #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LEN_W      = 8,
   parameter int CNT_W      = 16,
   parameter int MAX_BURST  = 128,
   parameter int PAGE_BYTES = 4096
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sts_clr,
   input logic              hdr_valid,
   input logic              hdr_ready,
   input logic [ADDR_W-1:0] hdr_addr,
   input logic [LEN_W-1:0]  hdr_len,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [DATA_W-1:0] wr_data,
   input logic              wr_last,
   input logic              ovf_err,
   input logic [CNT_W-1:0]  xfer_count
);

   a_r5_hdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && !hdr_ready |=> hdr_valid && $stable(hdr_addr) && $stable(hdr_len));

   a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |-> (hdr_len != '0) && (32'(hdr_len) <= 32'(MAX_BURST)));

   a_r4_no_page_cross: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |-> ((32'(hdr_addr) & 32'(PAGE_BYTES - 1)) + 32'(hdr_len)) <= 32'(PAGE_BYTES));

   a_r9_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_last));

   a_r3_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(hdr_valid && wr_valid));

   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err && !sts_clr |=> ovf_err);

   a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (xfer_count - $past(xfer_count)) <= CNT_W'(1));

endmodule

bind dma_wr_launcher dwl_launcher_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
   .MAX_BURST(MAX_BURST), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sts_clr    (sts_clr),
   .hdr_valid  (hdr_valid),
   .hdr_ready  (hdr_ready),
   .hdr_addr   (hdr_addr),
   .hdr_len    (hdr_len),
   .wr_valid   (wr_valid),
   .wr_ready   (wr_ready),
   .wr_data    (wr_data),
   .wr_last    (wr_last),
   .ovf_err    (ovf_err),
   .xfer_count (xfer_count)
);

// File: tb/dma_wr_launcher_bench.sv
module dma_wr_launcher_bench;

   localparam int DEPTH = 64;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [31:0] in_data;
   logic        cfg_addr_we, cfg_size_we, sts_clr;
   logic [31:0] cfg_addr_wdata;
   logic [15:0] cfg_size_wdata;
   logic [31:0] cfg_addr;
   logic [15:0] cfg_size;
   logic        xfer_done, ovf_err;
   logic [15:0] xfer_count;
   logic        hdr_valid, hdr_ready, wr_valid, wr_ready, wr_last;
   logic [31:0] hdr_addr, wr_data;
   logic [7:0]  hdr_len;

   always #4 clk = ~clk;

   dma_wr_launcher u_dma_wr_launcher (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .cfg_addr_we(cfg_addr_we), .cfg_addr_wdata(cfg_addr_wdata),
      .cfg_size_we(cfg_size_we), .cfg_size_wdata(cfg_size_wdata),
      .sts_clr(sts_clr), .cfg_addr(cfg_addr), .cfg_size(cfg_size),
      .xfer_done(xfer_done), .xfer_count(xfer_count), .ovf_err(ovf_err),
      .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_addr(hdr_addr),
      .hdr_len(hdr_len), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_data(wr_data), .wr_last(wr_last)
   );

   // {host address, size in bytes}
   localparam logic [47:0] VEC [5] = '{
      {32'h1000_0000, 16'd64},
      {32'h2000_0000, 16'd256},
      {32'h3000_0FC0, 16'd200},
      {32'h4000_0FF8, 16'd16},
      {32'h5000_0004, 16'd4}
   };

   int n_chk = 0, n_bad = 0;
   int wr_pat = 32'h100, exp_pat = 32'h100;
   int xfers = 0;

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cfg(input logic [31:0] a, input logic [15:0] s);
      cfg_addr_we = 1'b1; cfg_addr_wdata = a;
      cfg_size_we = 1'b1; cfg_size_wdata = s;
      @(negedge clk);
      cfg_addr_we = 1'b0; cfg_size_we = 1'b0;
   endtask

   task automatic push_words(input int n);
      for (int i = 0; i < n; i++) begin
         in_valid = 1'b1; in_data = wr_pat; wr_pat++;
         @(negedge clk);
      end
      in_valid = 1'b0;
   endtask

   task automatic pulse_clr();
      sts_clr = 1'b1;
      @(negedge clk);
      sts_clr = 1'b0;
   endtask

   // R3 R4 R5 R9: follow the bursts of one transfer
   task automatic collect(input logic [31:0] a0, input int size, input bit stall);
      logic [31:0] a = a0;
      int rem = size, beats = 0, blen = 0, t = 0, want;
      while (rem > 0 && t < 4000) begin
         hdr_ready = stall ? t[0] : 1'b1;
         wr_ready  = stall ? t[1] : 1'b1;
         if (beats == 0) begin
            if (hdr_valid) begin
               want = 4096 - int'(a % 4096);
               if (want > 128) want = 128;
               if (want > rem) want = rem;
               chk("R4 burst address", hdr_addr, a);
               chk("R4 burst length", hdr_len, want);
               if (hdr_ready) begin
                  beats = want / 4; blen = want;
               end
            end
         end else if (wr_valid && wr_ready) begin
            chk("R3 beat data", wr_data, exp_pat);
            chk("R3 last marker", wr_last, beats == 1);
            exp_pat++; beats--;
            if (beats == 0) begin
               a = a + blen; rem = rem - blen;
            end
         end
         t++;
         @(negedge clk);
      end
      chk("R4 transfer completes", rem, 0);
      hdr_ready = 1'b1; wr_ready = 1'b1;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] old_cnt;
      int base;
      rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
      cfg_addr_we = 1'b0; cfg_size_we = 1'b0; sts_clr = 1'b0;
      cfg_addr_wdata = '0; cfg_size_wdata = '0;
      hdr_ready = 1'b1; wr_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 hdr_valid", hdr_valid, 0);
      chk("R1 wr_valid", wr_valid, 0);
      chk("R1 done", xfer_done, 0);
      chk("R1 ovf", ovf_err, 0);
      chk("R1 count", xfer_count, 0);
      chk("R1 cfg regs", {cfg_addr, cfg_size}, 0);

      // table of transfers
      for (int v = 0; v < 5; v++) begin
         cfg(VEC[v][47:16], VEC[v][15:0]);
         exp_pat = wr_pat;
         push_words(int'(VEC[v][15:0]) / 4);
         chk("R2 no header yet", hdr_valid, 0);
         @(negedge clk);
         chk("R2 header one cycle after threshold", hdr_valid, 1);
         collect(VEC[v][47:16], int'(VEC[v][15:0]), v[0]);
         xfers++;
         chk("R7 done set", xfer_done, 1);
         chk("R7 count step", xfer_count, xfers);
         pulse_clr();
         chk("R7 done cleared", xfer_done, 0);
         chk("R7 count kept", xfer_count, xfers);
      end

      // R6: registers rewritten while a transfer is pending
      cfg(32'h6000_0100, 16'd128);
      hdr_ready = 1'b0;
      exp_pat = wr_pat;
      push_words(32);
      @(negedge clk);
      chk("R6 header pending", hdr_valid, 1);
      cfg(32'h7000_0000, 16'd8);
      chk("R6 latched address", hdr_addr, 32'h6000_0100);
      collect(32'h6000_0100, 128, 1'b1);
      xfers++;
      chk("R6 first transfer count", xfer_count, xfers);
      push_words(2);
      collect(32'h7000_0000, 8, 1'b0);
      xfers++;
      chk("R6 second transfer count", xfer_count, xfers);

      // R8: overflow while no transfer can start
      cfg(32'h8000_0000, 16'd0);
      base = wr_pat;
      push_words(DEPTH + 3);
      chk("R8 overflow flag", ovf_err, 1);
      chk("R2 size zero never starts", hdr_valid, 0);
      repeat (3) @(negedge clk);
      chk("R8 overflow sticky", ovf_err, 1);
      old_cnt = 32'(xfer_count);
      pulse_clr();
      chk("R8 overflow cleared", ovf_err, 0);
      chk("R7 count unaffected by clear", xfer_count, old_cnt);
      exp_pat = base;
      cfg(32'h8000_0000, 16'd256);
      collect(32'h8000_0000, 256, 1'b0);
      xfers++;
      chk("R8 only stored words sent", exp_pat, base + DEPTH);
      repeat (4) @(negedge clk);
      chk("R8 dropped words never queued", hdr_valid, 0);
      chk("R7 final count", xfer_count, xfers);
      cfg(32'h0, 16'd0);

      finish_run();
   end

endmodule